// File: doc/BRIEF.md
# JTAG Target Entry and TAP Reset Sequencer

This block drives the pins of a target device so that the device enters four-wire JTAG mode and its test access port begins in a known state. A single start pulse launches a fixed, timed pin program. First the reset and test-enable lines are raised and held while the target settles. Then a handshake on those two lines selects JTAG mode, and the reset line is handed back to the target as an input.

The TAP portion follows. Clock, mode-select and data-in are raised, and a parameterised number of test clocks with mode-select high walk the controller into Test-Logic-Reset. One clock with mode-select low moves it to Run-Test/Idle. Two timed low pulses on mode-select then perform the fuse check. All delays are counted in system-clock ticks set by parameters.

A done flag rises at the end of the program and stays high until the next start. Any start request that arrives while the program is running has no effect.

Top module: `jtag_entry_seq`

## Requirements
- R1: After a synchronous active-low reset, every pin output, the reset-line drive enable and done are 0, and they stay 0 until start is seen.
- R2: A start sampled high while idle or done begins the program: test-enable and reset high, reset driven (enable 1), clock, mode-select and data-in low, for SETTLE_TICKS cycles.
- R3: The entry handshake then follows in order, with the reset line driven throughout: reset low for 2*EDGE_TICKS cycles, test-enable low for EDGE_TICKS cycles, test-enable high for EDGE_TICKS cycles.
- R4: Reset is then driven high and released at once (enable 0), with test-enable high, for SETTLE_TICKS cycles. The enable stays 0 for the rest of the program.
- R5: TAP preparation sets clock, mode-select and data-in high for HALF_TICKS cycles.
- R6: TMS_CYCLES test clocks follow with mode-select high, each being HALF_TICKS cycles low and then HALF_TICKS cycles high. TMS_CYCLES must be at least 5.
- R7: One test clock with mode-select low follows (HALF_TICKS low, HALF_TICKS high). Mode-select then returns high.
- R8: The fuse check is two pulses with mode-select low for FUSE_TICKS cycles each. Each pulse is preceded and followed by HALF_TICKS cycles with mode-select high, and the clock stays high throughout.
- R9: At the end, done is 1 and clock, mode-select, data-in, test-enable and reset are 1 with the enable 0. This state holds until a new start, which restarts the program.
- R10: Start is ignored while the program is running, including in its final cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to run the program |
| tck_o | output | 1 | Test clock to target |
| tms_o | output | 1 | Test mode select to target |
| tdi_o | output | 1 | Test data in to target |
| tst_o | output | 1 | Test-enable line to target |
| rst_o | output | 1 | Reset line value to target |
| rst_oe_o | output | 1 | Drive enable for the reset line (0 = released) |
| done_o | output | 1 | Program finished; held until next start |

## Verification
Two events can coincide in one cycle: a new start request and the expiry of the last fuse-check step, which is the cycle the program moves to done. The bench raises start in exactly that last busy cycle. It expects done to appear on the following cycle, with no restart, so the request is treated as arriving while busy. A start issued one cycle later, while done is held, must restart the program cycle for cycle. A start raised in the middle of the test clocks must likewise leave the pin trace unchanged.

// File: rtl/jes_pkg.sv
// Shared types for the JTAG entry sequencer.
// Assumes: one step is active at a time; pins are decoded from the step.
package jes_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_RST_LO,
        ST_TST_LO,
        ST_TST_HI,
        ST_RELEASE,
        ST_TAP_PREP,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_RTI_LO,
        ST_RTI_HI,
        ST_FUSE_GAP,
        ST_FUSE_LO,
        ST_DONE
    } step_e;

    typedef struct packed {
        logic done;
        logic rst_oe;
        logic rst;
        logic tst;
        logic tdi;
        logic tms;
        logic tck;
    } pins_t;

endpackage

// File: rtl/jes_timer.sv
// Step duration timer: loads a count and decrements it to zero.
// Assumes: the loaded value is the step length minus one, so the
// expired flag is high during the final cycle of a step.
module jes_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    // Count register: load on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // Delays in R3 rely on a steady one-per-cycle countdown.
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/jes_step_fsm.sv
// Step sequencer: walks the entry, TAP reset and fuse-check steps.
// Assumes: every tick parameter is at least 1 and TMS_CYCLES >= 5.
module jes_step_fsm
    import jes_pkg::*;
#(
    parameter int SETTLE_TICKS = 1000,
    parameter int EDGE_TICKS   = 50,
    parameter int HALF_TICKS   = 4,
    parameter int FUSE_TICKS   = 50,
    parameter int TMS_CYCLES   = 6,
    parameter int TW           = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          expired,
    output logic          load,
    output logic [TW-1:0] load_val,
    output step_e         state
);

    localparam int RST_LOW_TICKS = 2 * EDGE_TICKS;
    localparam int CW            = $clog2(TMS_CYCLES + 1);
    localparam logic [CW-1:0] LAST_CLK = CW'(TMS_CYCLES - 1);

    step_e         nxt;
    logic          busy;
    logic          advance;
    logic [CW-1:0] clk_cnt;
    logic [1:0]    fuse_cnt;

    // Length of a step in cycles, minus one.
    function automatic logic [TW-1:0] dur(input step_e s);
        case (s)
            ST_SETTLE, ST_RELEASE: dur = TW'(SETTLE_TICKS - 1);
            ST_RST_LO:             dur = TW'(RST_LOW_TICKS - 1);
            ST_TST_LO, ST_TST_HI:  dur = TW'(EDGE_TICKS - 1);
            ST_FUSE_LO:            dur = TW'(FUSE_TICKS - 1);
            default:               dur = TW'(HALF_TICKS - 1);
        endcase
    endfunction

    assign busy    = (state != ST_IDLE) && (state != ST_DONE);
    assign advance = busy ? expired : start;

    // Successor step selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE, ST_DONE: nxt = ST_SETTLE;
            ST_SETTLE:        nxt = ST_RST_LO;
            ST_RST_LO:        nxt = ST_TST_LO;
            ST_TST_LO:        nxt = ST_TST_HI;
            ST_TST_HI:        nxt = ST_RELEASE;
            ST_RELEASE:       nxt = ST_TAP_PREP;
            ST_TAP_PREP:      nxt = ST_CLK_LO;
            ST_CLK_LO:        nxt = ST_CLK_HI;
            ST_CLK_HI:        nxt = (clk_cnt == LAST_CLK) ? ST_RTI_LO : ST_CLK_LO;
            ST_RTI_LO:        nxt = ST_RTI_HI;
            ST_RTI_HI:        nxt = ST_FUSE_GAP;
            ST_FUSE_GAP:      nxt = (fuse_cnt == 2'd2) ? ST_DONE : ST_FUSE_LO;
            ST_FUSE_LO:       nxt = ST_FUSE_GAP;
            default:          nxt = ST_IDLE;
        endcase
    end

    assign load     = advance && (nxt != ST_DONE);
    assign load_val = dur(nxt);

    // Step register: moves only when the current step ends or start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (advance)
            state <= nxt;
    end

    // Test clock and fuse pulse counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_cnt  <= '0;
            fuse_cnt <= '0;
        end else if (advance) begin
            if (state == ST_TAP_PREP)
                clk_cnt <= '0;
            else if (state == ST_CLK_HI)
                clk_cnt <= clk_cnt + 1'b1;
            if (state == ST_RTI_HI)
                fuse_cnt <= '0;
            else if (state == ST_FUSE_LO)
                fuse_cnt <= fuse_cnt + 1'b1;
        end
    end

    // A running step never changes before its timer expires, start or not.
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expired) |=> $stable(state));

    // Done is kept until a fresh start.
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !start) |=> (state == ST_DONE));

    // Run-Test/Idle is reached only after the full count of test clocks.
    p_clock_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RTI_LO) |-> ($past(clk_cnt) == LAST_CLK));

    // Exactly two fuse pulses precede done.
    p_two_pulses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DONE) |-> ($past(fuse_cnt) == 2'd2));

endmodule

// File: rtl/jes_pin_decode.sv
// Pin decoder: maps the active step onto the target pin levels.
// Assumes: pins are pure functions of the registered step, so they
// change on the clock edge that enters a step.
module jes_pin_decode
    import jes_pkg::*;
(
    input  step_e state,
    output pins_t pins
);

    // Per-step pin levels.
    always_comb begin
        pins = '0;
        case (state)
            ST_SETTLE:   pins = '{done:1'b0, rst_oe:1'b1, rst:1'b1, tst:1'b1, tdi:1'b0, tms:1'b0, tck:1'b0};
            ST_RST_LO:   pins = '{done:1'b0, rst_oe:1'b1, rst:1'b0, tst:1'b1, tdi:1'b0, tms:1'b0, tck:1'b0};
            ST_TST_LO:   pins = '{done:1'b0, rst_oe:1'b1, rst:1'b0, tst:1'b0, tdi:1'b0, tms:1'b0, tck:1'b0};
            ST_TST_HI:   pins = '{done:1'b0, rst_oe:1'b1, rst:1'b0, tst:1'b1, tdi:1'b0, tms:1'b0, tck:1'b0};
            ST_RELEASE:  pins = '{done:1'b0, rst_oe:1'b0, rst:1'b1, tst:1'b1, tdi:1'b0, tms:1'b0, tck:1'b0};
            ST_CLK_LO:   pins = '{done:1'b0, rst_oe:1'b0, rst:1'b1, tst:1'b1, tdi:1'b1, tms:1'b1, tck:1'b0};
            ST_RTI_LO:   pins = '{done:1'b0, rst_oe:1'b0, rst:1'b1, tst:1'b1, tdi:1'b1, tms:1'b0, tck:1'b0};
            ST_RTI_HI,
            ST_FUSE_LO:  pins = '{done:1'b0, rst_oe:1'b0, rst:1'b1, tst:1'b1, tdi:1'b1, tms:1'b0, tck:1'b1};
            ST_TAP_PREP,
            ST_CLK_HI,
            ST_FUSE_GAP: pins = '{done:1'b0, rst_oe:1'b0, rst:1'b1, tst:1'b1, tdi:1'b1, tms:1'b1, tck:1'b1};
            ST_DONE:     pins = '{done:1'b1, rst_oe:1'b0, rst:1'b1, tst:1'b1, tdi:1'b1, tms:1'b1, tck:1'b1};
            default:     pins = '0;
        endcase
    end

endmodule

// File: rtl/jtag_entry_seq.sv
// JTAG entry and TAP reset sequencer, top level.
// Assumes: start is synchronous to clk; all delays in clk ticks, each >= 1;
// TMS_CYCLES >= 5 so the TAP reaches Test-Logic-Reset from any state.
module jtag_entry_seq
    import jes_pkg::*;
#(
    parameter int SETTLE_TICKS = 1000,
    parameter int EDGE_TICKS   = 50,
    parameter int HALF_TICKS   = 4,
    parameter int FUSE_TICKS   = 50,
    parameter int TMS_CYCLES   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic tck_o,
    output logic tms_o,
    output logic tdi_o,
    output logic tst_o,
    output logic rst_o,
    output logic rst_oe_o,
    output logic done_o
);

    localparam int MAX_A = (SETTLE_TICKS > 2 * EDGE_TICKS) ? SETTLE_TICKS : 2 * EDGE_TICKS;
    localparam int MAX_B = (HALF_TICKS > FUSE_TICKS) ? HALF_TICKS : FUSE_TICKS;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAX_T + 1);

    logic          load;
    logic [TW-1:0] load_val;
    logic          expired;
    step_e         state;
    pins_t         pins;

    jes_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    jes_step_fsm #(
        .SETTLE_TICKS (SETTLE_TICKS),
        .EDGE_TICKS   (EDGE_TICKS),
        .HALF_TICKS   (HALF_TICKS),
        .FUSE_TICKS   (FUSE_TICKS),
        .TMS_CYCLES   (TMS_CYCLES),
        .TW           (TW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .state    (state)
    );

    jes_pin_decode u_dec (
        .state (state),
        .pins  (pins)
    );

    assign tck_o    = pins.tck;
    assign tms_o    = pins.tms;
    assign tdi_o    = pins.tdi;
    assign tst_o    = pins.tst;
    assign rst_o    = pins.rst;
    assign rst_oe_o = pins.rst_oe;
    assign done_o   = pins.done;

    // Test clocking only happens once reset is high and released.
    p_released_clocking_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck_o) |-> (rst_o && !rst_oe_o && tst_o));

    // Leaving done needs a start on the previous edge.
    p_restart_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> $past(start));

endmodule

// File: tb/jtag_entry_seq_test.sv
`timescale 1ns/1ps
module jtag_entry_seq_test;

    localparam int SETTLE = 6;
    localparam int EDGE   = 2;
    localparam int HALF   = 2;
    localparam int FUSE   = 3;
    localparam int NCLK   = 5;
    localparam int NENT   = 23;

    // {requirement, pins {done,oe,rst,tst,tdi,tms,tck}, cycles}
    localparam logic [14:0] TBL [NENT] = '{
        {4'd2, 7'b0111000, 4'd6},   // R2 settle
        {4'd3, 7'b0101000, 4'd4},   // R3 reset low, twice edge delay
        {4'd3, 7'b0100000, 4'd2},   // R3 test-enable low
        {4'd3, 7'b0101000, 4'd2},   // R3 test-enable high
        {4'd4, 7'b0011000, 4'd6},   // R4 reset high, released
        {4'd5, 7'b0011111, 4'd2},   // R5 TAP prep
        {4'd6, 7'b0011110, 4'd2},   // R6 clock 1 low
        {4'd6, 7'b0011111, 4'd2},
        {4'd6, 7'b0011110, 4'd2},   // R6 clock 2
        {4'd6, 7'b0011111, 4'd2},
        {4'd6, 7'b0011110, 4'd2},   // R6 clock 3
        {4'd6, 7'b0011111, 4'd2},
        {4'd6, 7'b0011110, 4'd2},   // R6 clock 4
        {4'd6, 7'b0011111, 4'd2},
        {4'd6, 7'b0011110, 4'd2},   // R6 clock 5
        {4'd6, 7'b0011111, 4'd2},
        {4'd7, 7'b0011100, 4'd2},   // R7 idle clock low
        {4'd7, 7'b0011101, 4'd2},   // R7 idle clock high
        {4'd8, 7'b0011111, 4'd2},   // R8 gap
        {4'd8, 7'b0011101, 4'd3},   // R8 first pulse
        {4'd8, 7'b0011111, 4'd2},   // R8 gap
        {4'd8, 7'b0011101, 4'd3},   // R8 second pulse
        {4'd8, 7'b0011111, 4'd2}    // R8 final gap
    };
    localparam logic [6:0] DONE_PINS = 7'b1011111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tck_o, tms_o, tdi_o, tst_o, rst_o, rst_oe_o, done_o;
    int   checks = 0;
    int   errors = 0;

    always #4 clk = ~clk;

    jtag_entry_seq #(
        .SETTLE_TICKS (SETTLE),
        .EDGE_TICKS   (EDGE),
        .HALF_TICKS   (HALF),
        .FUSE_TICKS   (FUSE),
        .TMS_CYCLES   (NCLK)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tck_o    (tck_o),
        .tms_o    (tms_o),
        .tdi_o    (tdi_o),
        .tst_o    (tst_o),
        .rst_o    (rst_o),
        .rst_oe_o (rst_oe_o),
        .done_o   (done_o)
    );

    function automatic logic [6:0] pins_now();
        return {done_o, rst_oe_o, rst_o, tst_o, tdi_o, tms_o, tck_o};
    endfunction

    task automatic chk(input int req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: pins got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Walks the whole program from a start pulse; optionally raises start
    // for one cycle at entry inj_e, cycle inj_c (R10).
    task automatic run_seq(input int inj_e, input int inj_c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int e = 0; e < NENT; e++) begin
            for (int c = 0; c < int'(TBL[e][3:0]); c++) begin
                chk(int'(TBL[e][14:11]), pins_now(), TBL[e][10:4]);
                start = (e == inj_e && c == inj_c);
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(9, pins_now(), DONE_PINS);   // R9 done reached, R10 no restart
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(1, pins_now(), 7'b0000000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(1, pins_now(), 7'b0000000);   // R1 idle without start

        // Full program with a start mid-clocking (R10)
        run_seq(8, 1);

        // R9 done held without start
        repeat (10) begin
            @(negedge clk);
            chk(9, pins_now(), DONE_PINS);
        end

        // R9 restart from done; R10 start in the final busy cycle
        run_seq(NENT - 1, 1);
        @(negedge clk);
        chk(10, pins_now(), DONE_PINS);   // R10 late start was ignored

        // R9 start while done restarts; then R1 reset mid-program
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(2, pins_now(), TBL[0][10:4]);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(1, pins_now(), 7'b0000000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(1, pins_now(), 7'b0000000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule